// File: doc/BRIEF.md
# Template-Driven Message Decode Sequencer

This block steers the decoding of packed binary messages whose layout is set by a template. Messages carry no length. A message starts with a presence bitmap field, followed by a template identifier field. The sequencer looks up the identifier to find the start of a microcode segment. It then runs that segment. Each consume instruction takes one field from the input stream and emits it as a tagged output beat. Conditional instructions test the next presence bit and either fall through or branch past an optional field or group. An end instruction closes the message, and the very next field is taken as the presence bitmap of a new message. Several messages can therefore sit back to back inside one datagram.

The microcode store, the template table and a small table of specialised segments are all loaded through one write port before traffic starts. A specialised entry matches an exact pair of template identifier and presence bitmap at the message header. On a hit it selects a branch-free segment written for that pair. On a miss the generic per-template segment is used. An identifier with no table entry pulses an error flag. The sequencer then discards fields up to and including the one marked as the end of the datagram.

The FSM states are PMAP (take bitmap), TID (take identifier and dispatch), BUB1 and BUB2 (the two empty slots after every taken branch), EXEC (run one instruction) and DRAIN (discard after an unknown identifier). The transitions are as follows:
- PMAP goes to TID on an accepted field.
- TID goes to BUB1 when the identifier is known. It goes to DRAIN when the identifier is unknown, or straight back to PMAP if that field is also the last one.
- BUB1 goes to BUB2, and BUB2 goes to EXEC.
- EXEC goes to BUB1 on a taken skip, a jump or a dispatch, and back to PMAP on END.
- DRAIN goes to PMAP on the last field.

Top module: `tmpl_seq`

## Requirements
- R1: After reset the block is in PMAP: fld_ready is 1, and out_valid and err_o are 0.
- R2: The first accepted field of a message loads the presence bitmap from its low 8 bits. The second field is the template identifier. After the identifier is accepted, two cycles pass with fld_ready low, so the first segment field is accepted 3 cycles after the identifier.
- R3: Instructions are 16 bits wide: opcode in [15:13], field type in [12:9] and target address in [8:0]. CONSUME (opcode 0) accepts one field. One cycle later it presents out_valid together with the template identifier, the field index (0 for the first field after a dispatch, then +1 per field), the instruction's type and the 64-bit field value.
- R4: SKIP_IF_ABSENT (opcode 1) takes the next presence bit, most significant bit first. When the bit is 1, execution continues at the next address with no lost cycle. When the bit is 0, it branches to the target with two empty cycles.
- R5: JUMP (opcode 2) branches to its target unconditionally, and costs three cycles in total.
- R6: END (opcode 4) finishes the message, and the next accepted field is treated as a new presence bitmap. The end-of-datagram marker is ignored at every point other than draining.
- R7: At the message header only, a valid specialised entry whose identifier and full 8-bit bitmap both match selects that entry's segment. Otherwise the generic template table is used.
- R8: An identifier that is 16 or above, or whose table entry is invalid, produces a one-cycle err_o pulse. Fields are then accepted and dropped, with no output beats, through the field that has fld_last set, and the next field is a presence bitmap.
- R9: TID_DISPATCH (opcode 3) accepts the next field as a new template identifier and keeps the remaining presence bits. It restarts the field index at 0 and branches to that template's segment with two empty cycles.
- R10: The write port selects its target with cfg_sel. Value 0 writes the instruction at cfg_addr from cfg_wdata[15:0]. Value 1 writes template entry cfg_addr with the valid bit in [9] and the start address in [8:0]. Value 2 writes specialised entry cfg_addr with the valid bit in [21], the bitmap in [20:13], the identifier in [12:9] and the start address in [8:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_valid | input | 1 | Input field present |
| fld_data | input | 64 | Input field value |
| fld_last | input | 1 | Field is the last one of its datagram |
| fld_ready | output | 1 | Sequencer accepts the field this cycle |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Write target: instruction, template or specialised entry |
| cfg_addr | input | 9 | Write address or entry index |
| cfg_wdata | input | 22 | Write data |
| out_valid | output | 1 | Decoded field beat valid |
| out_tid | output | 4 | Template identifier of the beat |
| out_idx | output | 8 | Field index within the template |
| out_type | output | 4 | Field type from the instruction |
| out_value | output | 64 | Field value |
| err_o | output | 1 | Pulse on an unknown template identifier |

## Verification
The bench measures the exact accept spacing of fields:
- A design that drops or adds a bubble after a taken skip, a jump or a dispatch shifts those gaps.
- A design that charges a cycle to a present-bit skip also shifts those gaps.

A specialised segment uses a field type of its own. If the pair lookup misses an exact bitmap or fires on a nested dispatch, the type stream shows it. If it ignores a partial bitmap match, the type stream shows that too. Unknown identifiers are sent with the datagram end on the identifier itself and with trailing junk fields. A design that drains one field too many or too few falls out of message alignment, and every later beat then mismatches. Random end-of-datagram flags are scattered through normal messages to catch a design that reacts to them outside draining.

// File: rtl/tmpl_seq_pkg.sv
package tmpl_seq_pkg;

    typedef enum logic [2:0] {
        OP_CONSUME  = 3'd0,
        OP_SKIP     = 3'd1,
        OP_JUMP     = 3'd2,
        OP_DISPATCH = 3'd3,
        OP_END      = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_PMAP  = 3'd0,
        S_TID   = 3'd1,
        S_BUB1  = 3'd2,
        S_BUB2  = 3'd3,
        S_EXEC  = 3'd4,
        S_DRAIN = 3'd5
    } seq_state_e;

    // field type codes carried by CONSUME instructions
    localparam logic [3:0] FT_U32 = 4'd1;
    localparam logic [3:0] FT_S32 = 4'd2;
    localparam logic [3:0] FT_U64 = 4'd3;
    localparam logic [3:0] FT_S64 = 4'd4;
    localparam logic [3:0] FT_DEC = 4'd5;
    localparam logic [3:0] FT_STR = 4'd6;

    // write port targets
    localparam logic [1:0] CFG_IMEM = 2'd0;
    localparam logic [1:0] CFG_TMPL = 2'd1;
    localparam logic [1:0] CFG_SPEC = 2'd2;

endpackage

// File: rtl/tmpl_seq_pmap.sv
// Presence bitmap shift register; the head bit is the next one tested.
module tmpl_seq_pmap #(
    parameter int PMAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PMAP_W-1:0] load_val,
    input  logic              pop,
    output logic              head,
    output logic [PMAP_W-1:0] bits
);
    logic [PMAP_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (pop) begin
            sr_q <= {sr_q[PMAP_W-2:0], 1'b0};
        end
    end

    assign head = sr_q[PMAP_W-1];
    assign bits = sr_q;
endmodule

// File: rtl/tmpl_seq_store.sv
// Microcode words, template table and specialised-pair table with one write port.
module tmpl_seq_store #(
    parameter int IMEM_DEPTH = 512,
    parameter int TT_DEPTH   = 16,
    parameter int SPEC_N     = 4,
    parameter int PMAP_W     = 8,
    parameter int CFG_W      = 22,
    localparam int PC_W      = $clog2(IMEM_DEPTH),
    localparam int TID_W     = $clog2(TT_DEPTH),
    localparam int INSTR_W   = 7 + PC_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [1:0]                         cfg_sel,
    input  logic [PC_W-1:0]                    cfg_addr,
    input  logic [CFG_W-1:0]                   cfg_wdata,
    input  logic [PC_W-1:0]                    rd_pc,
    output logic [INSTR_W-1:0]                 rd_instr,
    output logic [TT_DEPTH-1:0]                tt_v,
    output logic [TT_DEPTH-1:0][PC_W-1:0]      tt_a,
    output logic [SPEC_N-1:0]                  sp_v,
    output logic [SPEC_N-1:0][TID_W-1:0]       sp_tid,
    output logic [SPEC_N-1:0][PMAP_W-1:0]      sp_pmap,
    output logic [SPEC_N-1:0][PC_W-1:0]        sp_a
);
    import tmpl_seq_pkg::*;

    localparam int SP_VBIT = PC_W + TID_W + PMAP_W;

    logic [INSTR_W-1:0] imem [IMEM_DEPTH];

    always_ff @(posedge clk) begin
        if (cfg_we && cfg_sel == CFG_IMEM) begin
            imem[cfg_addr] <= cfg_wdata[INSTR_W-1:0];
        end
    end

    assign rd_instr = imem[rd_pc];

    for (genvar g = 0; g < TT_DEPTH; g++) begin : g_tt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tt_v[g] <= 1'b0;
                tt_a[g] <= '0;
            end else if (cfg_we && cfg_sel == CFG_TMPL && cfg_addr == PC_W'(g)) begin
                tt_v[g] <= cfg_wdata[PC_W];
                tt_a[g] <= cfg_wdata[PC_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < SPEC_N; g++) begin : g_sp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_v[g]    <= 1'b0;
                sp_tid[g]  <= '0;
                sp_pmap[g] <= '0;
                sp_a[g]    <= '0;
            end else if (cfg_we && cfg_sel == CFG_SPEC && cfg_addr == PC_W'(g)) begin
                sp_v[g]    <= cfg_wdata[SP_VBIT];
                sp_pmap[g] <= cfg_wdata[SP_VBIT-1 -: PMAP_W];
                sp_tid[g]  <= cfg_wdata[PC_W+TID_W-1 -: TID_W];
                sp_a[g]    <= cfg_wdata[PC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tmpl_seq_lookup.sv
// Turns an identifier field (and, at the header, the bitmap) into a segment start.
module tmpl_seq_lookup #(
    parameter int DATA_W   = 64,
    parameter int TT_DEPTH = 16,
    parameter int SPEC_N   = 4,
    parameter int PMAP_W   = 8,
    parameter int PC_W     = 9,
    localparam int TID_W   = $clog2(TT_DEPTH)
) (
    input  logic [DATA_W-1:0]                 tid_field,
    input  logic [PMAP_W-1:0]                 pmap,
    input  logic                              spec_en,
    input  logic [TT_DEPTH-1:0]               tt_v,
    input  logic [TT_DEPTH-1:0][PC_W-1:0]     tt_a,
    input  logic [SPEC_N-1:0]                 sp_v,
    input  logic [SPEC_N-1:0][TID_W-1:0]      sp_tid,
    input  logic [SPEC_N-1:0][PMAP_W-1:0]     sp_pmap,
    input  logic [SPEC_N-1:0][PC_W-1:0]       sp_a,
    output logic                              known,
    output logic [PC_W-1:0]                   start
);
    logic             in_range;
    logic [TID_W-1:0] tid;
    logic             sp_hit;
    logic [PC_W-1:0]  sp_start;

    assign in_range = (tid_field[DATA_W-1:TID_W] == '0);
    assign tid      = tid_field[TID_W-1:0];

    // lowest matching entry wins
    always_comb begin
        sp_hit   = 1'b0;
        sp_start = '0;
        for (int i = SPEC_N - 1; i >= 0; i--) begin
            if (spec_en && in_range && sp_v[i] && sp_tid[i] == tid && sp_pmap[i] == pmap) begin
                sp_hit   = 1'b1;
                sp_start = sp_a[i];
            end
        end
    end

    always_comb begin
        if (sp_hit) begin
            known = 1'b1;
            start = sp_start;
        end else begin
            known = in_range && tt_v[tid];
            start = tt_a[tid];
        end
    end
endmodule

// File: rtl/tmpl_seq.sv
module tmpl_seq #(
    parameter int DATA_W     = 64,
    parameter int PMAP_W     = 8,
    parameter int IMEM_DEPTH = 512,
    parameter int TT_DEPTH   = 16,
    parameter int SPEC_N     = 4,
    parameter int IDX_W      = 8,
    parameter int CFG_W      = 22,
    localparam int PC_W      = $clog2(IMEM_DEPTH),
    localparam int TID_W     = $clog2(TT_DEPTH),
    localparam int INSTR_W   = 7 + PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fld_valid,
    input  logic [DATA_W-1:0] fld_data,
    input  logic              fld_last,
    output logic              fld_ready,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PC_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              out_valid,
    output logic [TID_W-1:0]  out_tid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [3:0]        out_type,
    output logic [DATA_W-1:0] out_value,
    output logic              err_o
);
    import tmpl_seq_pkg::*;

    seq_state_e         state_q, state_d;
    logic [PC_W-1:0]    pc_q, pc_d;
    logic [TID_W-1:0]   tid_q, tid_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    logic [INSTR_W-1:0] instr;
    op_e                op;
    logic [3:0]         ftype;
    logic [PC_W-1:0]    tgt;

    logic [TT_DEPTH-1:0]            tt_v;
    logic [TT_DEPTH-1:0][PC_W-1:0]  tt_a;
    logic [SPEC_N-1:0]              sp_v;
    logic [SPEC_N-1:0][TID_W-1:0]   sp_tid;
    logic [SPEC_N-1:0][PMAP_W-1:0]  sp_pmap;
    logic [SPEC_N-1:0][PC_W-1:0]    sp_a;

    logic               lk_known;
    logic [PC_W-1:0]    lk_start;
    logic               pm_head;
    logic [PMAP_W-1:0]  pm_bits;

    logic               fire;
    logic               emit;
    logic               err_set;
    logic               pm_load;
    logic               pm_pop;
    logic               takes_tid;

    tmpl_seq_store #(
        .IMEM_DEPTH(IMEM_DEPTH), .TT_DEPTH(TT_DEPTH), .SPEC_N(SPEC_N),
        .PMAP_W(PMAP_W), .CFG_W(CFG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_pc(pc_q), .rd_instr(instr),
        .tt_v(tt_v), .tt_a(tt_a),
        .sp_v(sp_v), .sp_tid(sp_tid), .sp_pmap(sp_pmap), .sp_a(sp_a)
    );

    tmpl_seq_lookup #(
        .DATA_W(DATA_W), .TT_DEPTH(TT_DEPTH), .SPEC_N(SPEC_N),
        .PMAP_W(PMAP_W), .PC_W(PC_W)
    ) u_lookup (
        .tid_field(fld_data), .pmap(pm_bits), .spec_en(state_q == S_TID),
        .tt_v(tt_v), .tt_a(tt_a),
        .sp_v(sp_v), .sp_tid(sp_tid), .sp_pmap(sp_pmap), .sp_a(sp_a),
        .known(lk_known), .start(lk_start)
    );

    tmpl_seq_pmap #(.PMAP_W(PMAP_W)) u_pmap (
        .clk(clk), .rst_n(rst_n),
        .load(pm_load), .load_val(fld_data[PMAP_W-1:0]),
        .pop(pm_pop), .head(pm_head), .bits(pm_bits)
    );

    // instruction fields
    assign op    = op_e'(instr[INSTR_W-1 -: 3]);
    assign ftype = instr[PC_W+3 : PC_W];
    assign tgt   = instr[PC_W-1:0];

    // input acceptance
    always_comb begin
        unique case (state_q)
            S_PMAP, S_TID, S_DRAIN: fld_ready = 1'b1;
            S_EXEC:                 fld_ready = (op == OP_CONSUME) || (op == OP_DISPATCH);
            default:                fld_ready = 1'b0;
        endcase
    end

    assign fire      = fld_valid && fld_ready;
    assign takes_tid = (state_q == S_TID) || (state_q == S_EXEC && op == OP_DISPATCH);
    assign emit      = fire && state_q == S_EXEC && op == OP_CONSUME;
    assign err_set   = fire && takes_tid && !lk_known;
    assign pm_load   = fire && state_q == S_PMAP;
    assign pm_pop    = state_q == S_EXEC && op == OP_SKIP;

    // next state
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        tid_d   = tid_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_PMAP: begin
                if (fire) state_d = S_TID;
            end
            S_TID: begin
                if (fire) begin
                    if (lk_known) begin
                        pc_d    = lk_start;
                        tid_d   = fld_data[TID_W-1:0];
                        idx_d   = '0;
                        state_d = S_BUB1;
                    end else begin
                        state_d = fld_last ? S_PMAP : S_DRAIN;
                    end
                end
            end
            S_BUB1: state_d = S_BUB2;
            S_BUB2: state_d = S_EXEC;
            S_DRAIN: begin
                if (fire && fld_last) state_d = S_PMAP;
            end
            S_EXEC: begin
                unique case (op)
                    OP_CONSUME: begin
                        if (fire) begin
                            pc_d  = pc_q + PC_W'(1);
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end
                    OP_SKIP: begin
                        if (pm_head) begin
                            pc_d = pc_q + PC_W'(1);
                        end else begin
                            pc_d    = tgt;
                            state_d = S_BUB1;
                        end
                    end
                    OP_JUMP: begin
                        pc_d    = tgt;
                        state_d = S_BUB1;
                    end
                    OP_DISPATCH: begin
                        if (fire) begin
                            if (lk_known) begin
                                pc_d    = lk_start;
                                tid_d   = fld_data[TID_W-1:0];
                                idx_d   = '0;
                                state_d = S_BUB1;
                            end else begin
                                state_d = fld_last ? S_PMAP : S_DRAIN;
                            end
                        end
                    end
                    default: state_d = S_PMAP;
                endcase
            end
            default: state_d = S_PMAP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PMAP;
            pc_q    <= '0;
            tid_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            tid_q   <= tid_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tid   <= '0;
            out_idx   <= '0;
            out_type  <= '0;
            out_value <= '0;
            err_o     <= 1'b0;
        end else begin
            out_valid <= emit;
            err_o     <= err_set;
            if (emit) begin
                out_tid   <= tid_q;
                out_idx   <= idx_q;
                out_type  <= ftype;
                out_value <= fld_data;
            end
        end
    end
endmodule

// File: rtl/tmpl_seq_chk.sv
module tmpl_seq_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fld_valid,
    input logic                      fld_ready,
    input logic                      out_valid,
    input logic                      err_o,
    input tmpl_seq_pkg::seq_state_e  state
);
    import tmpl_seq_pkg::*;

    assert_beat_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fld_valid && fld_ready));

    assert_err_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(fld_valid && fld_ready));

    assert_bubble_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BUB1 |=> state == S_BUB2);

    assert_bubble_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BUB2 |=> state == S_EXEC);

    assert_bubble_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUB1 || state == S_BUB2) |-> !fld_ready);

    assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DRAIN |=> !out_valid);

    assert_header_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PMAP && fld_valid && fld_ready) |=> state == S_TID);
endmodule

bind tmpl_seq tmpl_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fld_valid(fld_valid), .fld_ready(fld_ready),
    .out_valid(out_valid), .err_o(err_o), .state(state_q)
);

// File: tb/tb_tmpl_seq.sv
module tb_tmpl_seq;
    localparam int NF = 800;
    localparam int NB = 2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fld_valid;
    logic [63:0] fld_data;
    logic        fld_last;
    logic        fld_ready;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [8:0]  cfg_addr;
    logic [21:0] cfg_wdata;
    logic        out_valid;
    logic [3:0]  out_tid;
    logic [7:0]  out_idx;
    logic [3:0]  out_type;
    logic [63:0] out_value;
    logic        err_o;

    always #10 clk = ~clk;

    tmpl_seq dut (
        .clk(clk), .rst_n(rst_n), .fld_valid(fld_valid), .fld_data(fld_data),
        .fld_last(fld_last), .fld_ready(fld_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_tid(out_tid), .out_idx(out_idx), .out_type(out_type),
        .out_value(out_value), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    logic [63:0] s_data [NF];
    bit          s_last [NF];
    int          acc    [NF];
    int          nf = 0;

    int          e_tid  [NB];
    int          e_idx  [NB];
    int          e_type [NB];
    logic [63:0] e_val  [NB];
    int          nb = 0;
    int          exp_err = 0;
    bit          rnd_last = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [21:0] ins(input int op, input int ty, input int tg);
        return {6'd0, op[2:0], ty[3:0], tg[8:0]};
    endfunction

    task automatic wr(input logic [1:0] sel, input int addr, input logic [21:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr[8:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic bit rl();
        return rnd_last && ($urandom_range(0, 7) == 0);
    endfunction

    task automatic add_f(input logic [63:0] d, input bit l);
        s_data[nf] = d; s_last[nf] = l; nf++;
    endtask

    task automatic fld(input int t, input int ty, inout int ix);
        logic [63:0] v;
        v = {$urandom, $urandom};
        add_f(v, rl());
        e_tid[nb] = t; e_idx[nb] = ix; e_type[nb] = ty; e_val[nb] = v; nb++;
        ix++;
    endtask

    // expected beats of one template body (R3, R4, R7, R9)
    task automatic body(input int t, input logic [7:0] pm, input bit top, input int nest);
        int ix = 0;
        case (t)
            0: begin
                if (top && pm == 8'h80) begin
                    fld(0, 9, ix); fld(0, 4, ix); fld(0, 5, ix); fld(0, 6, ix);
                end else begin
                    fld(0, 1, ix);
                    if (pm[7]) begin fld(0, 4, ix); fld(0, 5, ix); end
                    fld(0, 6, ix);
                end
            end
            1: begin
                fld(1, 2, ix);
                if (pm[7]) fld(1, 3, ix);
                if (pm[6]) fld(1, 7, ix);
            end
            default: begin
                fld(2, 1, ix);
                add_f(64'(nest), rl());
                body(nest, pm, 1'b0, 0);
            end
        endcase
    endtask

    task automatic msg(input logic [7:0] pm, input int t, input int nest);
        add_f({$urandom, 24'd0, pm}, rl());
        add_f(64'(t), rl());
        body(t, pm, 1'b1, nest);
    endtask

    task automatic bad(input logic [7:0] pm, input logic [63:0] t, input int junk);
        add_f(64'(pm), rl());
        add_f(t, junk == 0);
        for (int j = 0; j < junk; j++) add_f({$urandom, $urandom}, j == junk - 1);
        exp_err++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int ptr, oc, errs_seen, cyc, flush, n_dir;
        rst_n = 1'b0; fld_valid = 1'b0; fld_data = '0; fld_last = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(fld_ready == 1'b1, "R1 ready", 64'(fld_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
        chk(err_o == 1'b0, "R1 err", 64'(err_o), 0);

        // R10 microcode: template 0 @10, template 1 @40, template 2 @60, specialised @100
        wr(2'd0, 10, ins(0, 1, 0));  wr(2'd0, 11, ins(1, 0, 14));
        wr(2'd0, 12, ins(0, 4, 0));  wr(2'd0, 13, ins(0, 5, 0));
        wr(2'd0, 14, ins(0, 6, 0));  wr(2'd0, 15, ins(4, 0, 0));
        wr(2'd0, 40, ins(0, 2, 0));  wr(2'd0, 41, ins(2, 0, 45));
        for (int a = 42; a < 45; a++) wr(2'd0, a, ins(0, 15, 0));
        wr(2'd0, 45, ins(1, 0, 47)); wr(2'd0, 46, ins(0, 3, 0));
        wr(2'd0, 47, ins(1, 0, 49)); wr(2'd0, 48, ins(0, 7, 0));
        wr(2'd0, 49, ins(4, 0, 0));
        wr(2'd0, 60, ins(0, 1, 0));  wr(2'd0, 61, ins(3, 0, 0));
        wr(2'd0, 100, ins(0, 9, 0)); wr(2'd0, 101, ins(0, 4, 0));
        wr(2'd0, 102, ins(0, 5, 0)); wr(2'd0, 103, ins(0, 6, 0));
        wr(2'd0, 104, ins(4, 0, 0));
        wr(2'd1, 0, {12'd0, 1'b1, 9'd10});
        wr(2'd1, 1, {12'd0, 1'b1, 9'd40});
        wr(2'd1, 2, {12'd0, 1'b1, 9'd60});
        wr(2'd1, 3, {12'd0, 1'b0, 9'd40});          // written but invalid
        wr(2'd2, 0, {1'b1, 8'h80, 4'd0, 9'd100});

        // directed stream, no gaps
        msg(8'h80, 1, 0);                  // pos 0..3
        msg(8'h80, 0, 0);                  // pos 4..9   specialised hit
        msg(8'hC0, 0, 0);                  // pos 10..15 miss, generic
        bad(8'h00, 64'd20, 2);             // pos 16..19
        msg(8'h00, 2, 1);                  // pos 20..24 nested dispatch
        bad(8'h00, 64'd5, 0);              // pos 25..26
        n_dir = nf + 1;
        rnd_last = 1'b1;
        void'($urandom(32'd1234));
        while (nf < NF - 20) begin
            int k = $urandom_range(0, 9);
            if (k < 3) msg(8'($urandom_range(0, 255)), 0, 0);
            else if (k == 3) msg(8'h80, 0, 0);
            else if (k < 6) msg(8'($urandom_range(0, 255)), 1, 0);
            else if (k < 8) msg(8'($urandom_range(0, 255)), 2, $urandom_range(0, 1));
            else if (k == 8) bad(8'($urandom_range(0, 255)), 64'd3, $urandom_range(0, 3));
            else bad(8'($urandom_range(0, 255)), {$urandom, 32'd0}, $urandom_range(0, 3));
        end

        ptr = 0; oc = 0; errs_seen = 0; cyc = 0; flush = 0;
        while (ptr < nf || flush < 12) begin
            @(negedge clk);
            cyc++;
            if (ptr < nf && (ptr < n_dir || $urandom_range(0, 3) != 0)) begin
                fld_valid = 1'b1; fld_data = s_data[ptr]; fld_last = s_last[ptr];
            end else begin
                fld_valid = 1'b0; fld_data = '0; fld_last = 1'b0;
            end
            #1;
            if (out_valid) begin
                if (oc < nb) begin
                    chk(out_value == e_val[oc], "R3 value", out_value, e_val[oc]);
                    chk(32'(out_type) == e_type[oc], "R3/R7 type", 64'(out_type), 64'(e_type[oc]));
                    chk(32'(out_tid) == e_tid[oc], "R3/R9 tid", 64'(out_tid), 64'(e_tid[oc]));
                    chk(32'(out_idx) == e_idx[oc], "R3/R9 index", 64'(out_idx), 64'(e_idx[oc]));
                end else begin
                    chk(1'b0, "R8 extra beat", 64'(oc), 64'(nb));
                end
                oc++;
            end
            if (err_o) errs_seen++;
            if (fld_valid && fld_ready) begin
                acc[ptr] = cyc;
                ptr++;
            end
            if (ptr >= nf) flush++;
        end
        fld_valid = 1'b0;

        chk(oc == nb, "R3 beat count", 64'(oc), 64'(nb));
        chk(errs_seen == exp_err, "R8 error pulses", 64'(errs_seen), 64'(exp_err));
        // accept spacing in the directed part
        chk(acc[2] - acc[1] == 3, "R2 dispatch bubbles", 64'(acc[2] - acc[1]), 3);
        chk(acc[3] - acc[2] == 5, "R5 jump cost", 64'(acc[3] - acc[2]), 5);
        chk(acc[4] - acc[3] == 5, "R4 absent skip then R6 end", 64'(acc[4] - acc[3]), 5);
        chk(acc[6] - acc[5] == 3, "R7 specialised dispatch", 64'(acc[6] - acc[5]), 3);
        chk(acc[10] - acc[9] == 2, "R6 back-to-back header", 64'(acc[10] - acc[9]), 2);
        chk(acc[13] - acc[12] == 2, "R4 present skip no bubble", 64'(acc[13] - acc[12]), 2);
        chk(acc[18] - acc[17] == 1, "R8 drain start", 64'(acc[18] - acc[17]), 1);
        chk(acc[20] - acc[19] == 1, "R8 drain end", 64'(acc[20] - acc[19]), 1);
        chk(acc[23] - acc[22] == 1, "R9 dispatch accept", 64'(acc[23] - acc[22]), 1);
        chk(acc[24] - acc[23] == 3, "R9 dispatch bubbles", 64'(acc[24] - acc[23]), 3);
        chk(acc[27] - acc[26] == 1, "R8 last on identifier", 64'(acc[27] - acc[26]), 1);
        report();
    end
endmodule